// File: doc/BRIEF.md
# Network Controller Interrupt and Run Control

This block collects event pulses from the receive, transmit and remote-transfer data paths of a network controller, latches them in an 8-bit status register, and raises a single registered interrupt line whenever a latched event is enabled by a 7-bit mask. The host reads the status, mask and command registers through a small register port and acknowledges events by writing ones to the status bits it has handled.

The block also owns the controller's run state. A three-state machine (`ST_RUN`, `ST_DRAIN`, `ST_OFF`) tracks whether the controller is online, draining in-flight traffic after a stop request, or offline. The top status bit is a reset indication that the host cannot write. It is set when the controller is offline after a stop, and separately when the receive ring is overwritten. Each cause has its own clearing condition.

State transitions: `ST_OFF` is entered from reset. `ST_OFF -> ST_RUN` happens on a command write with start=1 and stop=0. `ST_RUN -> ST_DRAIN` happens on a command write with stop=1. `ST_DRAIN -> ST_RUN` happens on a command write with start=1 and stop=0, which takes priority. Otherwise `ST_DRAIN -> ST_OFF` happens in the first cycle with `busy` low.

Top module: `nic_irq_ctrl`

## Requirements
- R1: After reset, the command register reads 0x01, the status register reads 0x80, the mask reads 0x00, `online` is 0 and `irq` is 0.
- R2: A pulse on an event input sets its status bit on the next clock edge. The bit positions are: rx_ok=0, tx_ok=1, rx_err=2, tx_err=3, overwrite=4, counter overflow=5, remote transfer done=6. The bit stays set until the host clears it.
- R3: A status write (sel=1) with a 1 in bit position 0..6 clears that bit, and a 0 leaves it unchanged. Bit 7 is unaffected by any host write.
- R4: When an event and a host clear hit the same status bit in the same cycle, the bit ends up set.
- R5: A command write (sel=0) with bit0 (stop)=1 drops `online` on the next edge. Status bit 7 becomes 1 only on the edge after the first cycle in which `busy` is low.
- R6: A command write with bit1 (start)=1 and bit0 (stop)=0 brings the controller online and clears the stop cause of status bit 7. A write with both bits set does not. The command register reads back {6'b0, start, stop} as last written.
- R7: An overwrite pulse sets status bit 7 (and bit 4). This overwrite cause clears on a `ring_drained` pulse, or an overwrite wins if both arrive together. Bit 7 stays 1 while the stop cause is still present.
- R8: Status bit 5 sets when any bit of `tally_msb` goes from 0 to 1. A bit that stays high does not set it again after it has been cleared.
- R9: A mask write (sel=2) stores bits 6..0. Mask bit 7 always reads 0, and sel=3 reads 0x00.
- R10: `irq` equals the OR of status bits 6..0 ANDed with the mask, delayed by one register. Status bit 7 never drives `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_sel | input | 2 | Register select: 0 command, 1 status, 2 mask, 3 none |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the selected register (combinational) |
| ev_rx_ok | input | 1 | Frame received without error |
| ev_tx_ok | input | 1 | Frame sent without error |
| ev_rx_err | input | 1 | Receive error |
| ev_tx_err | input | 1 | Transmit error |
| ev_overwrite | input | 1 | Receive ring overwritten |
| tally_msb | input | TALLY_N | Top bit of each statistics counter |
| ev_rdma_done | input | 1 | Remote transfer complete |
| busy | input | 1 | Reception or transmission in progress |
| ring_drained | input | 1 | At least one frame removed from the ring |
| online | output | 1 | Controller may start new traffic |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest situation to reach is a status bit 7 that is held by both causes at once: an overwrite that arrives while a stop is still draining, followed by a ring drain that must not clear the bit. The stimulus holds `busy` high across the stop write, pulses an overwrite while the machine is in `ST_DRAIN`, then drops `busy` and drains the ring. It also pulses an event and a clear of the same bit together, and raises a second counter MSB while the first is still high, so that only edges are seen.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DRAIN = 2'd1,
        ST_OFF   = 2'd2
    } run_state_e;

    localparam int EV_W   = 7;
    localparam int STAT_W = EV_W + 1;

    localparam logic [1:0] SEL_CMD  = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_MASK = 2'd2;

    localparam int B_RX_OK = 0;
    localparam int B_TX_OK = 1;
    localparam int B_RX_ER = 2;
    localparam int B_TX_ER = 3;
    localparam int B_OVW   = 4;
    localparam int B_CNT   = 5;
    localparam int B_RDMA  = 6;
endpackage

// File: rtl/nic_tally_edge.sv
module nic_tally_edge #(
    parameter int TALLY_N = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TALLY_N-1:0] msb_in,
    output logic               any_rise
);
    logic [TALLY_N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= msb_in;
    end

    assign any_rise = |(msb_in & ~prev_q);
endmodule

// File: rtl/nic_stat_bank.sv
module nic_stat_bank
    import nic_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_W-1:0] ev,
    input  logic            clr_wr,
    input  logic [EV_W-1:0] clr_data,
    input  logic            mask_wr,
    input  logic [EV_W-1:0] mask_data,
    input  logic            drained,
    output logic [EV_W-1:0] stat_lo,
    output logic [EV_W-1:0] mask,
    output logic            ovw_cause
);
    // One sticky bit per event; set beats write-one-to-clear.
    for (genvar i = 0; i < EV_W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      stat_lo[i] <= 1'b0;
            else if (ev[i])                  stat_lo[i] <= 1'b1;
            else if (clr_wr && clr_data[i])  stat_lo[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask <= '0;
        else if (mask_wr) mask <= mask_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             ovw_cause <= 1'b0;
        else if (ev[B_OVW])     ovw_cause <= 1'b1;
        else if (drained)       ovw_cause <= 1'b0;
    end
endmodule

// File: rtl/nic_run_fsm.sv
module nic_run_fsm
    import nic_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic       cmd_stop,
    input  logic       cmd_start,
    input  logic       busy,
    output logic       online,
    output logic       stop_cause,
    output logic [1:0] cmd_bits
);
    run_state_e state, nxt;
    logic       go;

    assign go = cmd_wr && cmd_start && !cmd_stop;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:   if (cmd_wr && cmd_stop) nxt = ST_DRAIN;
            ST_DRAIN: begin
                if (go)         nxt = ST_RUN;
                else if (!busy) nxt = ST_OFF;
            end
            ST_OFF:   if (go) nxt = ST_RUN;
            default:  nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cmd_bits <= 2'b01;
        else if (cmd_wr) cmd_bits <= {cmd_start, cmd_stop};
    end

    always_comb begin
        online     = (state == ST_RUN);
        stop_cause = (state == ST_OFF);
    end
endmodule

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl
    import nic_irq_pkg::*;
#(
    parameter int TALLY_N = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic [1:0]         host_sel,
    input  logic [7:0]         host_wdata,
    output logic [7:0]         host_rdata,
    input  logic               ev_rx_ok,
    input  logic               ev_tx_ok,
    input  logic               ev_rx_err,
    input  logic               ev_tx_err,
    input  logic               ev_overwrite,
    input  logic [TALLY_N-1:0] tally_msb,
    input  logic               ev_rdma_done,
    input  logic               busy,
    input  logic               ring_drained,
    output logic               online,
    output logic               irq
);
    logic [EV_W-1:0] ev, stat_lo, mask;
    logic            cnt_rise, ovw_cause, stop_cause, rst_bit, irq_q;
    logic [1:0]      cmd_bits;

    nic_tally_edge #(.TALLY_N(TALLY_N)) u_edge (
        .clk(clk), .rst_n(rst_n), .msb_in(tally_msb), .any_rise(cnt_rise)
    );

    always_comb begin
        ev          = '0;
        ev[B_RX_OK] = ev_rx_ok;
        ev[B_TX_OK] = ev_tx_ok;
        ev[B_RX_ER] = ev_rx_err;
        ev[B_TX_ER] = ev_tx_err;
        ev[B_OVW]   = ev_overwrite;
        ev[B_CNT]   = cnt_rise;
        ev[B_RDMA]  = ev_rdma_done;
    end

    nic_stat_bank u_bank (
        .clk(clk), .rst_n(rst_n), .ev(ev),
        .clr_wr(host_wr && host_sel == SEL_STAT), .clr_data(host_wdata[EV_W-1:0]),
        .mask_wr(host_wr && host_sel == SEL_MASK), .mask_data(host_wdata[EV_W-1:0]),
        .drained(ring_drained), .stat_lo(stat_lo), .mask(mask), .ovw_cause(ovw_cause)
    );

    nic_run_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(host_wr && host_sel == SEL_CMD),
        .cmd_stop(host_wdata[0]), .cmd_start(host_wdata[1]),
        .busy(busy), .online(online), .stop_cause(stop_cause), .cmd_bits(cmd_bits)
    );

    assign rst_bit = stop_cause | ovw_cause;

    always_comb begin
        unique case (host_sel)
            SEL_CMD:  host_rdata = {6'b0, cmd_bits};
            SEL_STAT: host_rdata = {rst_bit, stat_lo};
            SEL_MASK: host_rdata = {1'b0, mask};
            default:  host_rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(stat_lo & mask);
    end
    assign irq = irq_q;
endmodule

// File: rtl/nic_irq_chk.sv
module nic_irq_chk #(
    parameter int TALLY_N = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               ev_rx_ok,
    input logic               ev_overwrite,
    input logic [TALLY_N-1:0] tally_msb,
    input logic [1:0]         host_sel,
    input logic [7:0]         host_rdata,
    input logic [6:0]         stat_lo,
    input logic [6:0]         mask,
    input logic               rst_bit,
    input logic               stop_cause,
    input logic               irq
);
    // R2
    rx_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_ok |=> stat_lo[0]);
    // R7
    ovw_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_overwrite |=> (rst_bit && stat_lo[4]));
    // R5
    stop_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_cause) |-> !$past(busy));
    // R8
    cnt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(tally_msb & ~$past(tally_msb))) |=> stat_lo[5]);
    // R9
    mask_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel == 2'd2) |-> !host_rdata[7]);
    // R10
    irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(stat_lo & mask))));
endmodule

bind nic_irq_ctrl nic_irq_chk #(.TALLY_N(TALLY_N)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .ev_rx_ok(ev_rx_ok),
    .ev_overwrite(ev_overwrite), .tally_msb(tally_msb), .host_sel(host_sel),
    .host_rdata(host_rdata), .stat_lo(stat_lo), .mask(mask), .rst_bit(rst_bit),
    .stop_cause(stop_cause), .irq(irq)
);

// File: tb/test_nic_irq_ctrl.sv
module test_nic_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int TN = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic host_wr = 0; logic [1:0] host_sel = 0; logic [7:0] host_wdata = 0;
    logic [7:0] host_rdata;
    logic ev_rx_ok = 0, ev_tx_ok = 0, ev_rx_err = 0, ev_tx_err = 0;
    logic ev_overwrite = 0, ev_rdma_done = 0, busy = 0, ring_drained = 0;
    logic [TN-1:0] tally_msb = '0;
    logic online, irq;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;
    string tag = "R1";

    // behavioural reference state
    int m_state;            // 0 run, 1 drain, 2 off
    bit [6:0] m_stat, m_mask;
    bit m_ovw, m_irq, m_stopq, m_startq;
    bit [TN-1:0] m_prev;

    always #(CLK_PERIOD/2) clk = ~clk;

    nic_irq_ctrl #(.TALLY_N(TN)) i_nic_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .ev_rx_ok(ev_rx_ok),
        .ev_tx_ok(ev_tx_ok), .ev_rx_err(ev_rx_err), .ev_tx_err(ev_tx_err),
        .ev_overwrite(ev_overwrite), .tally_msb(tally_msb), .ev_rdma_done(ev_rdma_done),
        .busy(busy), .ring_drained(ring_drained), .online(online), .irq(irq)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 2; m_stat = 0; m_mask = 0; m_ovw = 0; m_irq = 0;
            m_stopq = 1; m_startq = 0; m_prev = 0;
        end else begin
            bit [6:0] evs;
            bit go;
            m_irq = (m_stat & m_mask) != 0;
            evs = {ev_rdma_done, (tally_msb & ~m_prev) != 0, ev_overwrite,
                   ev_tx_err, ev_rx_err, ev_tx_ok, ev_rx_ok};
            m_prev = tally_msb;
            for (int i = 0; i < 7; i++) begin
                if (evs[i]) m_stat[i] = 1;
                else if (host_wr && host_sel == 1 && host_wdata[i]) m_stat[i] = 0;
            end
            if (host_wr && host_sel == 2) m_mask = host_wdata[6:0];
            if (ev_overwrite) m_ovw = 1; else if (ring_drained) m_ovw = 0;
            go = host_wr && host_sel == 0 && host_wdata[1] && !host_wdata[0];
            case (m_state)
                0: if (host_wr && host_sel == 0 && host_wdata[0]) m_state = 1;
                1: if (go) m_state = 0; else if (!busy) m_state = 2;
                default: if (go) m_state = 0;
            endcase
            if (host_wr && host_sel == 0) begin
                m_stopq = host_wdata[0]; m_startq = host_wdata[1];
            end
        end
    end

    function automatic logic [7:0] exp_rd();
        case (host_sel)
            0: return {6'b0, m_startq, m_stopq};
            1: return {(m_state == 2) || m_ovw, m_stat};
            2: return {1'b0, m_mask};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%02h expected=%02h (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("rdata", host_rdata, exp_rd());
            chk("online", {7'b0, online}, {7'b0, m_state == 0});
            // R10 irq is one register behind status and mask
            chk("irq", {7'b0, irq}, {7'b0, m_irq});
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] s, logic [7:0] d);
        host_wr = 1; host_sel = s; host_wdata = d;
        step();
        host_wr = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk); cycles++;
            if (cycles > 5000 && !done) begin
                checks++; errors++;
                $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cycles);
                finish_run();
            end
        end
    end

    initial begin
        step(3);
        rst_n = 1;
        tag = "R1";
        host_sel = 0; step(); host_sel = 1; step(); host_sel = 2; step(); host_sel = 3; step();
        tag = "R9";
        wr(2, 8'hFF); host_sel = 2; step();
        wr(2, 8'h00);
        tag = "R6";
        wr(0, 8'h02); host_sel = 0; step();
        tag = "R2";
        host_sel = 1;
        ev_rx_ok = 1; step(); ev_rx_ok = 0;
        ev_tx_ok = 1; step(); ev_tx_ok = 0;
        ev_rx_err = 1; step(); ev_rx_err = 0;
        ev_tx_err = 1; step(); ev_tx_err = 0;
        ev_rdma_done = 1; step(); ev_rdma_done = 0; step();
        tag = "R3";
        wr(1, 8'h05); host_sel = 1; step();
        wr(1, 8'h00); host_sel = 1; step();
        wr(1, 8'hFF); host_sel = 1; step();
        tag = "R4";
        ev_rx_ok = 1; ev_rdma_done = 1; wr(1, 8'h41); ev_rx_ok = 0; ev_rdma_done = 0;
        host_sel = 1; step();
        tag = "R10";
        wr(2, 8'h01); host_sel = 1; step(2);
        wr(1, 8'h01); step(2);
        wr(2, 8'h40); step(2);
        wr(2, 8'h00); step(2);
        wr(1, 8'h7F);
        tag = "R8";
        wr(2, 8'h20);
        tally_msb = 3'b001; host_sel = 1; step(2);
        wr(1, 8'h20); step(2);
        tally_msb = 3'b011; step(2);
        wr(1, 8'h20); tally_msb = 3'b000; step(2);
        tag = "R5";
        busy = 1; wr(0, 8'h01); host_sel = 1; step(4);
        tag = "R7";
        ev_overwrite = 1; step(); ev_overwrite = 0; step();
        tag = "R5";
        busy = 0; step(3);
        tag = "R7";
        ring_drained = 1; step(); ring_drained = 0; step();
        tag = "R6";
        wr(0, 8'h03); host_sel = 0; step(); host_sel = 1; step();
        wr(0, 8'h02); host_sel = 1; step(2);
        tag = "R7";
        ev_overwrite = 1; ring_drained = 1; step(); ev_overwrite = 0; ring_drained = 0; step();
        ring_drained = 1; step(); ring_drained = 0; step();
        tag = "R5";
        wr(0, 8'h01); host_sel = 0; step(3);
        tag = "R6";
        busy = 1; wr(0, 8'h01); wr(0, 8'h02); busy = 0; host_sel = 1; step(2);
        tag = "R3";
        wr(1, 8'hFF); host_sel = 1; step(2);
        finish_run();
    end
endmodule